// File: doc/BRIEF.md
# Debounced Panel Input Controller

This block conditions the raw contacts of a small front panel: four push buttons and a rotary knob that can also be pressed. Each button is filtered by a stable-time debouncer. The block gives a clean level for each button and a single-cycle strobe when that level rises. The lowest button is not given a strobe. Its filtered level is passed out as a reset for downstream logic, and it also clears the block's own editable state.

The knob builds a 16-bit data word, four bits at a time. Each press-and-release of the knob moves the edit cursor to the next 4-bit field, and after the last field it wraps back to the first. Each rotation detent adds one to the selected field or subtracts one from it, modulo 16. The other fields do not change. For example, starting from reset, eleven clockwise detents, two presses, three clockwise detents and then one counter-clockwise detent leave the word at 0x020B.

The filter length is set at elaboration. The simulation setting gives a 4-cycle filter and the hardware setting gives a 2^20-cycle filter.

Top module: `panel_input_ctrl`

## Requirements
- R1: A filtered level takes the value of its raw input once the raw input has differed from the level for LIMIT consecutive clock edges. LIMIT is 4 when SIM_MODE=1. If the raw input returns to the current level before that, the count restarts and the level does not change.
- R2: `btn_pulse[i]` is high for exactly one cycle, in the first cycle in which `btn_level[i]` is high. A falling level produces no pulse.
- R3: `sys_rst` is the filtered level of `btn_raw[0]`. While it is high, `data_word` is held at 0, the edit cursor is held on bits 3..0, and rotation has no effect.
- R4: The edit cursor advances by one 4-bit field on the filtered release (falling edge) of `knob_raw[0]`. The order is bits 3..0, then 7..4, then 11..8, then 15..12, and then back to 3..0. Rotation made while the knob is still held down acts on the field selected before that press.
- R5: A filtered rising edge of `knob_raw[1]` is one detent. If the filtered `knob_raw[2]` is 0 at that edge, the selected field is incremented. If it is 1, the selected field is decremented. Every other field keeps its value.
- R6: The selected field wraps modulo 16: incrementing 0xF gives 0x0, and decrementing 0x0 gives 0xF.
- R7: While `arst_n` is low, and in the first cycle after it is released, all outputs are 0.
- R8: A knob press, a falling edge of `knob_raw[1]`, a change of `knob_raw[2]`, and a glitch shorter than LIMIT on any knob line each leave `data_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| btn_raw | input | 4 | Raw button contacts; bit 0 is the reset button |
| knob_raw | input | 3 | Raw knob contacts: bit 0 is the press, bits 1 and 2 are the rotation phases |
| sys_rst | output | 1 | Filtered level of button 0 |
| btn_level | output | 3 | Filtered levels of buttons 3..1 |
| btn_pulse | output | 3 | One-cycle strobes on the rising filtered level of buttons 3..1 |
| data_word | output | 16 | Word edited with the knob |

## Verification
The hardest state to reach is one where a single field holds a chosen value while its neighbours hold different values. Getting there takes a long, ordered sequence of presses and detents, and each of those must outlast the filter. The stimulus therefore sweeps every field through more than a full cycle in both directions, which passes both wrap points. It then checks, after every detent, the whole word against an arithmetic model of the word and the cursor. Held presses and sub-filter glitches are mixed in to confirm that selection only moves on release and that short pulses are absorbed.

// File: rtl/panel_pkg.sv
package panel_pkg;
  localparam int unsigned FIELD_W = 4;

  function automatic logic [FIELD_W-1:0] field_step(logic [FIELD_W-1:0] v, logic up);
    return up ? v + 1'b1 : v - 1'b1;
  endfunction

  function automatic int unsigned filter_len(bit sim_mode);
    return sim_mode ? 4 : (1 << 20);
  endfunction
endpackage

// File: rtl/deb_filter.sv
module deb_filter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic raw,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          lvl_d1_q;
  logic          flip;

  assign flip = (raw != lvl_q) && (cnt_q == LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q    <= '0;
      lvl_q    <= 1'b0;
      lvl_d1_q <= 1'b0;
    end else begin
      lvl_d1_q <= lvl_q;
      if (raw == lvl_q) begin
        cnt_q <= '0;
      end else if (flip) begin
        lvl_q <= raw;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level = lvl_q;
  assign rise  = lvl_q & ~lvl_d1_q;
  assign fall  = ~lvl_q & lvl_d1_q;

  assert_level_follows_raw_R1: assert property (@(posedge clk) disable iff (!arst_n)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(raw) && $past(cnt_q) == LAST));

  assert_rise_single_R2: assert property (@(posedge clk) disable iff (!arst_n)
    rise |=> !rise);
endmodule

// File: rtl/knob_decoder.sv
module knob_decoder #(
  parameter int unsigned LIMIT   = 4,
  parameter int unsigned NFIELDS = 4,
  localparam int unsigned SEL_W  = $clog2(NFIELDS)
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             clr,
  input  logic [2:0]       knob_raw,
  output logic [SEL_W-1:0] sel,
  output logic             inc,
  output logic             dec
);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NFIELDS - 1);

  logic [2:0] k_lvl, k_rise, k_fall;
  logic [SEL_W-1:0] sel_q;
  logic press_done;
  logic detent;

  for (genvar g = 0; g < 3; g++) begin : g_knob_deb
    deb_filter #(.LIMIT(LIMIT)) deb_i (
      .clk(clk), .arst_n(arst_n), .raw(knob_raw[g]),
      .level(k_lvl[g]), .rise(k_rise[g]), .fall(k_fall[g]));
  end

  assign press_done = k_fall[0];
  assign detent     = k_rise[1] & ~clr;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)         sel_q <= '0;
    else if (clr)        sel_q <= '0;
    else if (press_done) sel_q <= (sel_q == SEL_LAST) ? '0 : sel_q + 1'b1;
  end

  assign sel = sel_q;
  assign inc = detent & ~k_lvl[2];
  assign dec = detent &  k_lvl[2];

  assert_cursor_steps_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (!$past(clr) && sel_q != $past(sel_q)) |->
      ($past(press_done) && (sel_q == $past(sel_q) + 1'b1 || sel_q == '0)));

  assert_one_step_per_detent_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (inc || dec) |=> !(inc || dec));
endmodule

// File: rtl/field_editor.sv
module field_editor #(
  parameter int unsigned NFIELDS = 4,
  localparam int unsigned SEL_W  = $clog2(NFIELDS),
  localparam int unsigned W      = NFIELDS * panel_pkg::FIELD_W
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  input  logic             inc,
  input  logic             dec,
  output logic [W-1:0]     word
);
  import panel_pkg::*;

  function automatic logic [W-1:0] field_mask(logic [SEL_W-1:0] s);
    return {{(W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << (s * FIELD_W);
  endfunction

  logic [FIELD_W-1:0] fld_q [NFIELDS];

  for (genvar g = 0; g < NFIELDS; g++) begin : g_field
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                                       fld_q[g] <= '0;
      else if (clr)                                      fld_q[g] <= '0;
      else if ((inc || dec) && sel == SEL_W'(g))         fld_q[g] <= field_step(fld_q[g], inc);
    end
    assign word[g*FIELD_W +: FIELD_W] = fld_q[g];
  end

  assert_clear_holds_zero_R3: assert property (@(posedge clk) disable iff (!arst_n)
    clr |=> (word == '0));

  assert_other_fields_kept_R5: assert property (@(posedge clk) disable iff (!arst_n)
    !clr |=> (((word ^ $past(word)) & ~field_mask($past(sel))) == '0));

  assert_idle_no_change_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (!clr && !inc && !dec) |=> $stable(word));
endmodule

// File: rtl/panel_input_ctrl.sv
module panel_input_ctrl #(
  parameter bit          SIM_MODE = 1'b0,
  parameter int unsigned NBTN     = 4,
  parameter int unsigned NFIELDS  = 4,
  localparam int unsigned LIMIT   = panel_pkg::filter_len(SIM_MODE),
  localparam int unsigned SEL_W   = $clog2(NFIELDS),
  localparam int unsigned W       = NFIELDS * panel_pkg::FIELD_W
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic [NBTN-1:0] btn_raw,
  input  logic [2:0]      knob_raw,
  output logic            sys_rst,
  output logic [NBTN-1:1] btn_level,
  output logic [NBTN-1:1] btn_pulse,
  output logic [W-1:0]    data_word
);
  logic [NBTN-1:0] b_lvl, b_rise, b_fall;
  logic [SEL_W-1:0] sel;
  logic inc, dec;

  for (genvar g = 0; g < NBTN; g++) begin : g_btn_deb
    deb_filter #(.LIMIT(LIMIT)) deb_i (
      .clk(clk), .arst_n(arst_n), .raw(btn_raw[g]),
      .level(b_lvl[g]), .rise(b_rise[g]), .fall(b_fall[g]));
  end

  assign sys_rst   = b_lvl[0];
  assign btn_level = b_lvl[NBTN-1:1];
  assign btn_pulse = b_rise[NBTN-1:1];

  knob_decoder #(.LIMIT(LIMIT), .NFIELDS(NFIELDS)) knob_i (
    .clk(clk), .arst_n(arst_n), .clr(sys_rst), .knob_raw(knob_raw),
    .sel(sel), .inc(inc), .dec(dec));

  field_editor #(.NFIELDS(NFIELDS)) edit_i (
    .clk(clk), .arst_n(arst_n), .clr(sys_rst), .sel(sel),
    .inc(inc), .dec(dec), .word(data_word));

  assert_pulse_needs_level_R2: assert property (@(posedge clk) disable iff (!arst_n)
    (btn_pulse != '0) |-> ((btn_pulse & ~btn_level) == '0));

  assert_no_pulse_on_fall_R2: assert property (@(posedge clk) disable iff (!arst_n)
    ((b_fall[NBTN-1:1] & btn_pulse) == '0));
endmodule

// File: tb/panel_input_ctrl_tb.sv
`timescale 1ns/1ps
module panel_input_ctrl_tb_top;
  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic [3:0] btn_raw = '0;
  logic [2:0] knob_raw = '0;
  logic sys_rst;
  logic [3:1] btn_level, btn_pulse;
  logic [15:0] data_word;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_word = '0;
  int exp_sel = 0;
  int pulse_cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  panel_input_ctrl #(.SIM_MODE(1'b1)) dut_i (
    .clk(clk), .arst_n(arst_n), .btn_raw(btn_raw), .knob_raw(knob_raw),
    .sys_rst(sys_rst), .btn_level(btn_level), .btn_pulse(btn_pulse),
    .data_word(data_word));

  always @(negedge clk) if (btn_pulse[1]) pulse_cycles++;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_step(logic [15:0] w, int s, bit up);
    int f;
    f = (w >> (4 * s)) & 15;
    f = (f + (up ? 1 : 15)) % 16;
    return (w & ~(16'hF << (4 * s))) | (16'(f) << (4 * s));
  endfunction

  task automatic detent(bit up);
    knob_raw[2] = ~up; tick(6);
    knob_raw[1] = 1'b1; tick(6);
    knob_raw[1] = 1'b0; tick(6);
    knob_raw[2] = 1'b0; tick(6);
    if (!sys_rst) exp_word = model_step(exp_word, exp_sel, up);
  endtask

  task automatic press();
    knob_raw[0] = 1'b1; tick(6);
    chk("R8 press hold", 32'(data_word), 32'(exp_word));
    knob_raw[0] = 1'b0; tick(6);
    exp_sel = (exp_sel + 1) % 4;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(2);
    chk("R7 reset word", 32'(data_word), 0);
    chk("R7 reset flags", {sys_rst, btn_level, btn_pulse}, 0);
    arst_n = 1'b1;
    tick(1);
    chk("R7 after release", {sys_rst, btn_level, btn_pulse, data_word}, 0);

    // R1 / R2: exact latency and single strobe
    btn_raw[1] = 1'b1;
    tick(3);
    chk("R1 level before limit", 32'(btn_level[1]), 0);
    tick(1);
    chk("R1 level at limit", 32'(btn_level[1]), 1);
    chk("R2 pulse first cycle", 32'(btn_pulse[1]), 1);
    tick(1);
    chk("R2 pulse gone", 32'(btn_pulse[1]), 0);
    tick(6);
    btn_raw[1] = 1'b0;
    tick(10);
    chk("R1 level fell", 32'(btn_level[1]), 0);
    chk("R2 one pulse cycle total", 32'(pulse_cycles), 1);

    // R1 glitch on button 2 and button 3
    btn_raw[2] = 1'b1; tick(3); btn_raw[2] = 1'b0; tick(6);
    chk("R1 glitch ignored", 32'(btn_level), 0);
    btn_raw[3] = 1'b1; tick(6);
    chk("R1 button3 level", 32'(btn_level), 32'h4);
    btn_raw[3] = 1'b0; tick(6);

    // R8 glitch on rotation phase
    knob_raw[1] = 1'b1; tick(3); knob_raw[1] = 1'b0; tick(6);
    chk("R8 knob glitch", 32'(data_word), 0);

    // R5 / R6 sweep across all fields, both directions, through both wraps
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 19; i++) begin
        detent(1'b1);
        chk("R5 R6 increment", 32'(data_word), 32'(exp_word));
      end
      for (int i = 0; i < 22; i++) begin
        detent(1'b0);
        chk("R5 R6 decrement", 32'(data_word), 32'(exp_word));
      end
      press();
    end
    chk("R4 cursor wrapped", 32'(exp_sel), 0);

    // R4: rotation while held acts on old field
    knob_raw[0] = 1'b1; tick(6);
    detent(1'b1);
    chk("R4 held rotation old field", 32'(data_word), 32'(exp_word));
    knob_raw[0] = 1'b0; tick(6);
    exp_sel = (exp_sel + 1) % 4;
    detent(1'b1);
    chk("R4 next field after release", 32'(data_word), 32'(exp_word));

    // R3 reset button
    btn_raw[0] = 1'b1; tick(6);
    chk("R3 sys_rst high", 32'(sys_rst), 1);
    chk("R3 word cleared", 32'(data_word), 0);
    detent(1'b1);
    chk("R3 rotation ignored", 32'(data_word), 0);
    btn_raw[0] = 1'b0; tick(6);
    chk("R3 sys_rst low", 32'(sys_rst), 0);
    exp_word = '0; exp_sel = 0;

    // R5 worked example: 0x030B then 0x020B
    for (int i = 0; i < 11; i++) detent(1'b1);
    press(); press();
    for (int i = 0; i < 3; i++) detent(1'b1);
    chk("R5 example build", 32'(data_word), 32'h030B);
    detent(1'b0);
    chk("R5 example decrement", 32'(data_word), 32'h020B);
    chk("R5 model agrees", 32'(exp_word), 32'h020B);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule